// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared, level-sensitive PCI interrupt request lines onto sixteen legacy interrupt controller inputs. Each request line has one steering byte. The byte either names the controller input that the line drives or, at a value of sixteen or more, disconnects the line. Every controller input is the wired-OR of all request lines currently steered to it. A registered level map, indexed by output and line, holds the routed state. The outputs come from that map and are re-evaluated on every clock, so any change to a request line or to a steering byte reaches them one cycle after the change.

The steering bytes sit behind a small configuration-bus shim. It has a byte address, four byte enables and 32-bit write and read data. One dword-wide write at the block's base offset can update any subset of the four bytes in a single cycle. Two combinational helpers complete the block. A route query returns, for one request line, whether it is connected and to which input. A slot swizzle maps a device's interrupt pin to one of the shared lines.

Top module: `pirq_router`

## Requirements
- R1: After reset every steering byte reads 0x80, which means disabled, the level map is cleared, and all sixteen controller outputs are low.
- R2: A write with `cfg_addr[7:2]` equal to 0x60>>2 updates steering byte i, held in data bits [8i+7:8i], only when `cfg_be[i]` is set. The steering byte for line 0 is bits [7:0] and the one for line 3 is bits [31:24]. Reads at that dword return all four bytes in the same layout.
- R3: Writes to any other dword address are ignored, and reads at any other address return zero.
- R4: Controller output o is high one clock after a clock edge at which some request line with steering value o is high. Otherwise it is low.
- R5: A request line whose steering byte is 16 or larger (for example 0x10, 0x80, 0xFF) drives no output.
- R6: After a steering byte changes, the outputs follow the new routing at the next clock edge, without any further write.
- R7: The route query for line `qry_line` gives `qry_en`=1 and `qry_irq` equal to the steering value when that value is below 16. For a value of 16 or more it gives `qry_en`=0 and `qry_irq`=0.
- R8: The slot swizzle returns line = (pin + (devfn >> 3) − 1) mod 4. Pin is 0 for A through 3 for D.
- R9: Two or more lines steered to the same output combine as an OR: the output stays high while any one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_req | input | 4 | Shared request lines, active high, level |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| pic_irq | output | 16 | Controller input levels (registered) |
| qry_line | input | 2 | Line selected for the route query |
| qry_en | output | 1 | Selected line is connected |
| qry_irq | output | 4 | Output number of the selected line |
| swz_devfn | input | 8 | Device/function number for the swizzle |
| swz_pin | input | 2 | Interrupt pin, 0 = A … 3 = D |
| swz_line | output | 2 | Shared line selected by the swizzle |

## Verification
The assertions assume that the inputs are valid at every clock edge once reset is released. They also assume that a steering byte the checker samples is the value the bank will hold one edge later, so `cfg_wr` is never X while the block is out of reset. The stimulus meets this by driving all inputs a short time after each rising edge and by holding `cfg_wr` low except in single-cycle write pulses. The random phase uses only the defined request and byte-enable widths, and mixes steering values below and above sixteen. This covers both the connected and the disconnected branch.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   typedef logic [7:0] steer_t;
   localparam steer_t STEER_RESET = 8'h80;
   localparam int     BUS_BYTES   = 4;
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
   import pirq_pkg::*;
#(
   parameter int          N_LINES   = 4,
   parameter logic [7:0]  BASE_ADDR = 8'h60
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic [7:0]                  addr,
   input  logic [BUS_BYTES-1:0]        be,
   input  logic [8*BUS_BYTES-1:0]      wdata,
   output logic [8*BUS_BYTES-1:0]      rdata,
   output logic [N_LINES-1:0][7:0]     steer
);
   if (N_LINES < 1 || N_LINES > BUS_BYTES) begin : g_bad_lines
      $error("pirq_cfg_regs: N_LINES must fit one bus word");
   end
   if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
      $error("pirq_cfg_regs: BASE_ADDR must be dword aligned");
   end

   logic                     hit;
   logic [8*BUS_BYTES-1:0]   word;

   assign hit = (addr[7:2] == BASE_ADDR[7:2]);

   for (genvar b = 0; b < BUS_BYTES; b++) begin : g_byte
      if (b < N_LINES) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)
               steer[b] <= STEER_RESET;
            else if (wr && hit && be[b])
               steer[b] <= wdata[8*b +: 8];
         end
         assign word[8*b +: 8] = steer[b];

         assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && hit && be[b]) |=> (steer[b] == $past(wdata[8*b +: 8])));
         assert_byte_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !be[b]) |=> $stable(steer[b]));
      end else begin : g_pad
         assign word[8*b +: 8] = 8'h00;
      end
   end

   assign rdata = hit ? word : '0;

   assert_miss_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !hit) |=> $stable(steer));
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
   import pirq_pkg::*;
#(
   parameter int N_LINES = 4,
   parameter int N_OUTS  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_LINES-1:0]       req,
   input  logic [N_LINES-1:0][7:0]  steer,
   output logic [N_OUTS-1:0]        irq
);
   localparam int MAP_BITS = N_LINES * N_OUTS;

   if (N_OUTS < 1 || N_OUTS > 255) begin : g_bad_outs
      $error("pirq_level_map: N_OUTS must be 1..255");
   end

   logic [MAP_BITS-1:0] map_q;
   logic [MAP_BITS-1:0] map_d;
   logic [N_LINES-1:0][N_OUTS-1:0] col;

   for (genvar o = 0; o < N_OUTS; o++) begin : g_out
      for (genvar l = 0; l < N_LINES; l++) begin : g_line
         assign map_d[o*N_LINES + l] = req[l] && (steer[l] == 8'(o));
         assign col[l][o]            = map_q[o*N_LINES + l];
      end
      assign irq[o] = |map_q[o*N_LINES +: N_LINES];

      assert_out_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
         irq[o] |-> $past(|req));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) map_q <= '0;
      else        map_q <= map_d;
   end

   for (genvar l = 0; l < N_LINES; l++) begin : g_chk
      assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col[l]));
      assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ({24'b0, steer[l]} >= 32'(N_OUTS)) |=> (col[l] == '0));
   end
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
   parameter int N_LINES = 4,
   localparam int LW     = $clog2(N_LINES)
) (
   input  logic [7:0]    devfn,
   input  logic [LW-1:0] pin,
   output logic [LW-1:0] line
);
   if (N_LINES < 2) begin : g_bad
      $error("pirq_swizzle: N_LINES must be at least 2");
   end

   int sum;
   always_comb sum = int'(pin) + int'(devfn[7:3]) + N_LINES - 1;

   if ((N_LINES & (N_LINES - 1)) == 0) begin : g_pow2
      assign line = sum[LW-1:0];
   end else begin : g_mod
      int rem;
      always_comb rem = sum % N_LINES;
      assign line = rem[LW-1:0];
   end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_pkg::*;
#(
   parameter int         N_LINES   = 4,
   parameter int         N_OUTS    = 16,
   parameter logic [7:0] BASE_ADDR = 8'h60,
   localparam int        LW        = $clog2(N_LINES),
   localparam int        OW        = $clog2(N_OUTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_LINES-1:0]    pci_req,
   input  logic                  cfg_wr,
   input  logic [7:0]            cfg_addr,
   input  logic [3:0]            cfg_be,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata,
   output logic [N_OUTS-1:0]     pic_irq,
   input  logic [LW-1:0]         qry_line,
   output logic                  qry_en,
   output logic [OW-1:0]         qry_irq,
   input  logic [7:0]            swz_devfn,
   input  logic [LW-1:0]         swz_pin,
   output logic [LW-1:0]         swz_line
);
   logic [N_LINES-1:0][7:0] steer;
   steer_t                  sel;

   pirq_cfg_regs #(.N_LINES(N_LINES), .BASE_ADDR(BASE_ADDR)) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .addr  (cfg_addr),
      .be    (cfg_be),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .steer (steer)
   );

   pirq_level_map #(.N_LINES(N_LINES), .N_OUTS(N_OUTS)) i_map (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (pci_req),
      .steer (steer),
      .irq   (pic_irq)
   );

   pirq_swizzle #(.N_LINES(N_LINES)) i_swz (
      .devfn (swz_devfn),
      .pin   (swz_pin),
      .line  (swz_line)
   );

   assign sel     = steer[qry_line];
   assign qry_en  = ({24'b0, sel} < 32'(N_OUTS));
   assign qry_irq = qry_en ? sel[OW-1:0] : '0;

   assert_route_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_en && pci_req[qry_line]) |=> pic_irq[$past(qry_irq)]);
endmodule

// File: tb/test_pirq_router.sv
`timescale 1ns/1ps
module test_pirq_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pci_req = '0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = 8'h60;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [15:0] pic_irq;
   logic [1:0]  qry_line = '0;
   logic        qry_en;
   logic [3:0]  qry_irq;
   logic [7:0]  swz_devfn = '0;
   logic [1:0]  swz_pin = '0;
   logic [1:0]  swz_line;

   pirq_router i_pirq_router (
      .clk(clk), .rst_n(rst_n), .pci_req(pci_req), .cfg_wr(cfg_wr),
      .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .pic_irq(pic_irq), .qry_line(qry_line),
      .qry_en(qry_en), .qry_irq(qry_irq), .swz_devfn(swz_devfn),
      .swz_pin(swz_pin), .swz_line(swz_line));

   always #4 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit run = 0;
   int st[4];
   logic [15:0] out_m = '0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_word(input logic [7:0] a);
      if (a[7:2] != 6'h18) return 32'h0;
      return {st[3][7:0], st[2][7:0], st[1][7:0], st[0][7:0]};
   endfunction

   // behavioural reference, updated at each rising edge
   always @(posedge clk) begin
      logic [15:0] nxt;
      if (!rst_n) begin
         foreach (st[i]) st[i] = 128;
         out_m = '0;
      end else begin
         nxt = '0;
         for (int l = 0; l < 4; l++)
            if (pci_req[l] && st[l] < 16) nxt[st[l]] = 1'b1;
         out_m = nxt;
         if (cfg_wr && cfg_addr[7:2] == 6'h18)
            for (int i = 0; i < 4; i++)
               if (cfg_be[i]) st[i] = int'((cfg_wdata >> (8*i)) & 32'hFF);
      end
   end

   // continuous comparison each cycle
   always @(negedge clk) begin
      if (run) begin
         chk(pic_irq == out_m, "R4 outputs", pic_irq, out_m);
         chk(cfg_rdata == model_word(cfg_addr), "R2 readback", cfg_rdata, model_word(cfg_addr));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
      cfg_wr = 1'b1; cfg_addr = a; cfg_be = b; cfg_wdata = d;
      step();
      cfg_wr = 1'b0; cfg_addr = 8'h60; cfg_be = '0;
   endtask

   task automatic settle();
      step(); step();
      @(negedge clk);
   endtask

   initial begin
      pci_req = 4'hF;
      repeat (4) step();
      rst_n = 1'b1;
      step();
      run = 1;
      @(negedge clk);
      // R1 reset values, R5 disabled lines drive nothing
      chk(cfg_rdata == 32'h80808080, "R1 reset steering", cfg_rdata, 32'h80808080);
      chk(pic_irq == 16'h0, "R1 outputs low after reset", pic_irq, 0);
      step(); @(negedge clk);
      chk(pic_irq == 16'h0, "R5 reset value 0x80 disables", pic_irq, 0);

      step();
      wr(8'h60, 4'hF, 32'h03020100);
      settle();
      chk(pic_irq == 16'h000F, "R4 lines to 0..3", pic_irq, 16'h000F);

      step();
      wr(8'h61, 4'b0010, 32'h00000500);
      @(negedge clk);
      chk(cfg_rdata == 32'h03020500, "R2 byte enable", cfg_rdata, 32'h03020500);
      step(); @(negedge clk);
      chk(pic_irq == 16'h002D, "R6 reroute line1 to 5", pic_irq, 16'h002D);

      step();
      wr(8'h60, 4'b0100, 32'h00050000);
      pci_req = 4'b0010; settle();
      chk(pic_irq == 16'h0020, "R9 line1 on shared output", pic_irq, 16'h0020);
      step(); pci_req = 4'b0100; settle();
      chk(pic_irq == 16'h0020, "R9 line2 on shared output", pic_irq, 16'h0020);
      step(); pci_req = 4'b0110; settle();
      chk(pic_irq == 16'h0020, "R9 both on shared output", pic_irq, 16'h0020);
      step(); pci_req = 4'b0000; settle();
      chk(pic_irq == 16'h0000, "R9 none high", pic_irq, 0);

      step(); pci_req = 4'b0001;
      wr(8'h60, 4'b0001, 32'h00000010); settle();
      chk(pic_irq == 16'h0, "R5 value 0x10 disables", pic_irq, 0);
      step(); wr(8'h60, 4'b0001, 32'h000000FF); settle();
      chk(pic_irq == 16'h0, "R5 value 0xFF disables", pic_irq, 0);
      step(); wr(8'h60, 4'b0001, 32'h0000000F); settle();
      chk(pic_irq == 16'h8000, "R5 value 15 enabled", pic_irq, 16'h8000);

      // R6 exact timing: old routing one cycle after write, new routing after that
      step(); wr(8'h60, 4'b0001, 32'h00000007);
      @(negedge clk);
      chk(pic_irq == 16'h8000, "R6 old route until map update", pic_irq, 16'h8000);
      step(); @(negedge clk);
      chk(pic_irq == 16'h0080, "R6 new route after map update", pic_irq, 16'h0080);

      // R3 other addresses
      step(); wr(8'h64, 4'hF, 32'h00000000);
      wr(8'h5C, 4'hF, 32'h01010101);
      @(negedge clk);
      chk(cfg_rdata == 32'h03050507, "R3 foreign writes ignored", cfg_rdata, 32'h03050507);
      step(); cfg_addr = 8'h64; @(negedge clk);
      chk(cfg_rdata == 32'h0, "R3 foreign read zero", cfg_rdata, 0);
      step(); cfg_addr = 8'h60;

      // R7 route query
      wr(8'h60, 4'hF, 32'h20_0C_80_09);
      for (int l = 0; l < 4; l++) begin
         int v;
         qry_line = 2'(l); step(); @(negedge clk);
         v = st[l];
         chk(qry_en == (v < 16), "R7 route enable", qry_en, (v < 16));
         chk(qry_irq == ((v < 16) ? 4'(v) : 4'h0), "R7 route target", qry_irq, (v < 16) ? v : 0);
      end

      // R8 swizzle
      foreach (st[k]) ;
      for (int d = 0; d < 8; d++) begin
         logic [7:0] dv;
         dv = (d == 7) ? 8'hFF : 8'(d * 8 + d);
         for (int p = 0; p < 4; p++) begin
            int e;
            swz_devfn = dv; swz_pin = 2'(p); #1;
            e = (p + int'(dv >> 3) + 3) % 4;
            chk(swz_line == 2'(e), "R8 swizzle", swz_line, e);
         end
      end

      // random mix: R4 R6 R9 via continuous compare
      for (int n = 0; n < 400; n++) begin
         step();
         pci_req = 4'($urandom);
         if (($urandom % 5) == 0) begin
            logic [31:0] w;
            w = $urandom;
            for (int i = 0; i < 4; i++)
               if (w[8*i+7]) w[8*i +: 8] = 8'(w[8*i +: 4]);
            wr(8'h60 + 8'($urandom % 3) * 8'h4, 4'($urandom), w);
         end
      end
      settle();
      run = 0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule